// File: doc/BRIEF.md
# Overcurrent Fault Timer with Tick-Quantized Delay

This block turns a sampled discharge-overcurrent comparator result into a latched fault. The comparator is evaluated once per sample-rate enable pulse (a 32 kHz rate in the intended system). The delay before a fault is declared is not counted in samples. It is counted in coarse ticks from a free-running timebase that fires once every 80 sample enables, which is 2.5 ms at 32 kHz.

Overcurrent does not begin in step with the timebase. For that reason the block first waits for the next tick after onset, and only then counts the number of ticks that the selected delay code asks for. The time from onset to fault is therefore the target tick count plus a fraction of one tick that depends on phase. For example, code 0 gives 7.5 to 10 ms. Any sample that shows no overcurrent before the target is reached abandons the attempt.

Once the fault is declared it drives three outputs: a status bit, a discharge-FET enable that is forced low, and an alert line to the host. All three stay latched until the host pulses a clear strobe while the comparator no longer reports overcurrent.

The control is a four-state machine:
- `ST_IDLE`: no overcurrent seen; the tick counter is zero.
- `ST_SYNC`: overcurrent seen; the block waits for the first tick.
- `ST_COUNT`: the block counts ticks toward the target.
- `ST_FAULT`: the fault is latched.

The transitions are:
- onset: `ST_IDLE` to `ST_SYNC`, on a sample with overcurrent, which also latches the delay code.
- align: `ST_SYNC` to `ST_COUNT`, on a tick sample with overcurrent.
- trip: `ST_COUNT` to `ST_FAULT`, on the tick that completes the target.
- dropout: `ST_SYNC` or `ST_COUNT` to `ST_IDLE`, on a sample without overcurrent.
- release: `ST_FAULT` to `ST_IDLE`, on a clear strobe while the comparator is low.

Top module: `oc_fault_timer`

## Requirements
- R1: After reset, `fault_stat` is 0, `dsg_fet_en` is 1 and `alert` is 0, and the tick phase counter is zero.
- R2: A tick occurs on every 80th sample enable after reset. Counting sample enables from 0, the tick falls on those whose index modulo 80 is 79. The tick counter only advances on a tick sample that sees overcurrent.
- R3: The 2-bit `delay_sel` code selects a target of 2^(code+2)-1 ticks: code 0 gives 3, code 1 gives 7, code 2 gives 15 and code 3 gives 31.
- R4: Count the onset sample as position 0. Let d0 (1 to 80) be the number of samples to the first tick strictly after onset. `fault_stat` is then set by the sample at position d0 + 80*target, so the delay always falls between target*80+1 and (target+1)*80 samples.
- R5: A sample without overcurrent before the trip sample returns the block to idle with the counter at zero. If overcurrent is removed exactly on the would-be trip sample, no fault occurs, and the next onset starts a full new delay.
- R6: In the cycle the fault is declared, `fault_stat` and `alert` go to 1 and `dsg_fet_en` goes to 0, all together. Before that, they hold their reset values.
- R7: The fault outputs stay latched, even when overcurrent disappears, until `clr_stb` is pulsed while `oc_detect` is 0. A `clr_stb` pulse while `oc_detect` is 1 leaves the fault in place.
- R8: The delay code is captured on the onset sample. Changing `delay_sel` while counting has no effect on that attempt.
- R9: `clr_stb` has no effect while the block is waiting for a tick or counting ticks; the trip time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle comparator sample enable (sample rate) |
| oc_detect | input | 1 | Comparator result, 1 = discharge overcurrent |
| delay_sel | input | 2 | Delay code, target = 2^(code+2)-1 ticks |
| clr_stb | input | 1 | Host status-clear pulse |
| fault_stat | output | 1 | Sticky overcurrent-in-discharge status |
| dsg_fet_en | output | 1 | Discharge FET enable, 0 while faulted |
| alert | output | 1 | Host interrupt, 1 while faulted |

## Verification
The bench starts overcurrent at each of the 80 tick phases with code 0 and requires the exact trip sample given in R4. A design that counted the onset tick, or that counted samples rather than ticks, would trip one tick early or far too soon at some phase. Pulses are cut off exactly on the would-be trip sample and a whole tick before it. This catches an off-by-one target compare, because such a design would trip on a pulse that is too short. Further checks cover three cases:
- A clear issued while overcurrent persists: a design that drops the fault here releases the FET too early.
- A code change during counting: a design that rereads the code lengthens or shortens a delay already under way.
- A clear issued mid-count: a design that restarts the counter here trips late.

// File: rtl/oct_pkg.sv
package oct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_COUNT = 2'd2,
        ST_FAULT = 2'd3
    } oct_state_e;

    // Tick target for a delay code: each code doubles the previous and adds one.
    function automatic int unsigned oct_target_ticks(input int unsigned code);
        return (32'd1 << (code + 32'd2)) - 32'd1;
    endfunction

endpackage

// File: rtl/oct_tickgen.sv
module oct_tickgen #(
    parameter int unsigned TICK_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    output logic tick_o
);
    localparam int unsigned PH_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_DIV - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (sample_en) begin
            if (phase_q == PH_LAST) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + PH_W'(1);
            end
        end
    end

    assign tick_o = sample_en && (phase_q == PH_LAST);

endmodule

// File: rtl/oct_delay_cnt.sv
module oct_delay_cnt
    import oct_pkg::*;
#(
    parameter int unsigned CODE_W = 2,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  target_o,
    output logic              last_o
);
    localparam int unsigned NUM_CODES = 1 << CODE_W;

    logic [CNT_W-1:0] tgt_tab [NUM_CODES];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target_q;

    for (genvar c = 0; c < NUM_CODES; c++) begin : g_tgt
        assign tgt_tab[c] = CNT_W'(oct_target_ticks(c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            target_q <= tgt_tab[0];
        end else if (clr_i) begin
            cnt_q    <= '0;
        end else if (load_i) begin
            cnt_q    <= '0;
            target_q <= tgt_tab[code_i];
        end else if (inc_i) begin
            cnt_q    <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o    = cnt_q;
    assign target_o = target_q;
    assign last_o   = (cnt_q == (target_q - CNT_W'(1)));

endmodule

// File: rtl/oct_fault_fsm.sv
module oct_fault_fsm
    import oct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       oc_i,
    input  logic       tick_i,
    input  logic       clr_i,
    input  logic       last_i,
    output logic       cnt_load_o,
    output logic       cnt_clr_o,
    output logic       cnt_inc_o,
    output oct_state_e state_o,
    output logic       fault_o,
    output logic       dsg_en_o,
    output logic       alert_o
);
    oct_state_e state_q;
    oct_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_load_o = 1'b0;
        cnt_clr_o  = 1'b0;
        cnt_inc_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sample_en && oc_i) begin
                    state_d    = ST_SYNC;
                    cnt_load_o = 1'b1;
                end
            end
            ST_SYNC: begin
                if (sample_en) begin
                    if (!oc_i) begin
                        state_d   = ST_IDLE;
                        cnt_clr_o = 1'b1;
                    end else if (tick_i) begin
                        state_d = ST_COUNT;
                    end
                end
            end
            ST_COUNT: begin
                if (sample_en) begin
                    if (!oc_i) begin
                        state_d   = ST_IDLE;
                        cnt_clr_o = 1'b1;
                    end else if (tick_i) begin
                        if (last_i) begin
                            state_d = ST_FAULT;
                        end else begin
                            cnt_inc_o = 1'b1;
                        end
                    end
                end
            end
            ST_FAULT: begin
                if (clr_i && !oc_i) begin
                    state_d   = ST_IDLE;
                    cnt_clr_o = 1'b1;
                end
            end
            default: begin
                state_d   = ST_IDLE;
                cnt_clr_o = 1'b1;
            end
        endcase
    end

    always_comb begin
        fault_o  = 1'b0;
        dsg_en_o = 1'b1;
        alert_o  = 1'b0;
        if (state_q == ST_FAULT) begin
            fault_o  = 1'b1;
            dsg_en_o = 1'b0;
            alert_o  = 1'b1;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/oc_fault_timer.sv
module oc_fault_timer
    import oct_pkg::*;
#(
    parameter int unsigned TICK_DIV = 80,
    parameter int unsigned CODE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              oc_detect,
    input  logic [CODE_W-1:0] delay_sel,
    input  logic              clr_stb,
    output logic              fault_stat,
    output logic              dsg_fet_en,
    output logic              alert
);
    localparam int unsigned NUM_CODES = 1 << CODE_W;
    localparam int unsigned CNT_W     = NUM_CODES + 1;

    logic             tick_s;
    logic             load_s;
    logic             clr_s;
    logic             inc_s;
    logic             last_s;
    logic [CNT_W-1:0] cnt_s;
    logic [CNT_W-1:0] target_s;
    oct_state_e       state_s;

    oct_tickgen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .tick_o    (tick_s)
    );

    oct_delay_cnt #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_s),
        .clr_i    (clr_s),
        .inc_i    (inc_s),
        .code_i   (delay_sel),
        .cnt_o    (cnt_s),
        .target_o (target_s),
        .last_o   (last_s)
    );

    oct_fault_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .oc_i       (oc_detect),
        .tick_i     (tick_s),
        .clr_i      (clr_stb),
        .last_i     (last_s),
        .cnt_load_o (load_s),
        .cnt_clr_o  (clr_s),
        .cnt_inc_o  (inc_s),
        .state_o    (state_s),
        .fault_o    (fault_stat),
        .dsg_en_o   (dsg_fet_en),
        .alert_o    (alert)
    );

endmodule

// File: rtl/oct_checker.sv
module oct_checker
    import oct_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_en,
    input logic             oc_detect,
    input logic             clr_stb,
    input logic             tick_s,
    input oct_state_e       state_s,
    input logic [CNT_W-1:0] cnt_s,
    input logic [CNT_W-1:0] target_s,
    input logic             fault_stat,
    input logic             dsg_fet_en,
    input logic             alert
);
    // R4
    trip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_stat) |-> $past(sample_en && oc_detect && tick_s));

    // R6
    trip_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_stat) |-> ($fell(dsg_fet_en) && $rose(alert)));

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stat && !(clr_stb && !oc_detect)) |=> fault_stat);

    // R7
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stat && clr_stb && !oc_detect) |=> (!fault_stat && dsg_fet_en && !alert));

    // R5
    dropout_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_s == ST_SYNC || state_s == ST_COUNT) && sample_en && !oc_detect)
        |=> (state_s == ST_IDLE && cnt_s == '0));

    // R2
    count_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cnt_s) && cnt_s != '0) |-> $past(tick_s && oc_detect));

    // R8
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_s == ST_COUNT) |=> $stable(target_s));

    // R9
    clear_while_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_s == ST_SYNC || state_s == ST_COUNT) && clr_stb && !sample_en)
        |=> ($stable(state_s) && $stable(cnt_s)));

endmodule

bind oc_fault_timer oct_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .oc_detect  (oc_detect),
    .clr_stb    (clr_stb),
    .tick_s     (tick_s),
    .state_s    (state_s),
    .cnt_s      (cnt_s),
    .target_s   (target_s),
    .fault_stat (fault_stat),
    .dsg_fet_en (dsg_fet_en),
    .alert      (alert)
);

// File: tb/oc_fault_timer_tb.sv
module oc_fault_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 80;
    localparam int NVEC       = 8;
    localparam int NO_EVT     = -1000000;

    // code, onset phase, oc hold relative to expected trip, trip expected
    localparam int VEC [NVEC][4] = '{
        '{1,  0, 10000, 1},
        '{2, 40, 10000, 1},
        '{3, 79, 10000, 1},
        '{0, 10,     0, 0},
        '{0, 10,     1, 1},
        '{1, 79,     0, 0},
        '{0,  0,   -80, 0},
        '{2,  5,     1, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       oc_detect = 1'b0;
    logic [1:0] delay_sel = 2'd0;
    logic       clr_stb = 1'b0;
    logic       fault_stat;
    logic       dsg_fet_en;
    logic       alert;

    int  gidx = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_fault_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .oc_detect  (oc_detect),
        .delay_sel  (delay_sel),
        .clr_stb    (clr_stb),
        .fault_stat (fault_stat),
        .dsg_fet_en (dsg_fet_en),
        .alert      (alert)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_sample();
        @(negedge clk) sample_en = 1'b1;
        @(negedge clk) sample_en = 1'b0;
        gidx++;
    endtask

    task automatic pulse_clr();
        @(negedge clk) clr_stb = 1'b1;
        @(negedge clk) clr_stb = 1'b0;
    endtask

    function automatic int exp_delay(input int code, input int g0);
        int r;
        int d0;
        r  = g0 % TDIV;
        d0 = (r == TDIV - 1) ? TDIV : (TDIV - 1 - r);
        return d0 + ((1 << (code + 2)) - 1) * TDIV;
    endfunction

    task automatic measure(input int code, input int phase, input int adj,
                           input int clr_at, input int sw_code, input int sw_at,
                           output int trip, output bit outs_ok, output int exp);
        int g0;
        int hold;
        oc_detect = 1'b0;
        while ((gidx % TDIV) != phase) do_sample();
        g0        = gidx;
        exp       = exp_delay(code, g0);
        hold      = exp + adj;
        delay_sel = 2'(code);
        oc_detect = 1'b1;
        trip      = -1;
        outs_ok   = 1'b1;
        for (int i = 0; i < exp + 200; i++) begin
            if (i == hold) oc_detect = 1'b0;
            if (i == sw_at) delay_sel = 2'(sw_code);
            if (i == clr_at) pulse_clr();
            do_sample();
            if (fault_stat) begin
                trip    = i;
                outs_ok = !dsg_fet_en && alert;
                break;
            end else if (!dsg_fet_en || alert) begin
                outs_ok = 1'b0;
            end
        end
    endtask

    task automatic release_fault();
        oc_detect = 1'b0;
        pulse_clr();
        check(!fault_stat && dsg_fet_en && !alert, "R7 release", int'(fault_stat), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int trip;
        int exp;
        bit ok;

        repeat (3) @(negedge clk);
        // R1 reset values
        check(fault_stat == 1'b0, "R1 fault_stat", int'(fault_stat), 0);
        check(dsg_fet_en == 1'b1, "R1 dsg_fet_en", int'(dsg_fet_en), 1);
        check(alert == 1'b0, "R1 alert", int'(alert), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!fault_stat && dsg_fet_en && !alert, "R1 after release", int'(fault_stat), 0);

        // table walk: R3 targets, R4 timing, R5 short pulses
        for (int v = 0; v < NVEC; v++) begin
            measure(VEC[v][0], VEC[v][1], VEC[v][2], NO_EVT, 0, NO_EVT, trip, ok, exp);
            if (VEC[v][3] != 0) begin
                check(trip == exp, "R3 R4 vector trip sample", trip, exp);
                check(ok, "R6 vector outputs", int'(ok), 1);
                release_fault();
            end else begin
                check(trip == -1, "R5 short pulse no trip", trip, -1);
                check(ok, "R6 idle outputs", int'(ok), 1);
                pulse_clr();
            end
        end

        // R2 R4: code 0 onset at every tick phase
        for (int ph = 0; ph < TDIV; ph++) begin
            measure(0, ph, 10000, NO_EVT, 0, NO_EVT, trip, ok, exp);
            check(trip == exp, "R4 phase sweep exact", trip, exp);
            check(trip >= 3 * TDIV + 1 && trip <= 4 * TDIV, "R4 phase sweep range", trip, 3 * TDIV);
            release_fault();
        end

        // R8: code change mid count ignored
        measure(0, 20, 10000, NO_EVT, 3, 50, trip, ok, exp);
        check(trip == exp, "R8 code latched at onset", trip, exp);
        release_fault();

        // R9: clear strobe while counting ignored
        measure(1, 33, 10000, 100, 0, NO_EVT, trip, ok, exp);
        check(trip == exp, "R9 clear during count", trip, exp);

        // R7: clear with overcurrent still present is ignored
        pulse_clr();
        check(fault_stat && !dsg_fet_en && alert, "R7 clear ignored while oc", int'(fault_stat), 1);

        // R7: sticky after overcurrent goes away
        oc_detect = 1'b0;
        repeat (100) do_sample();
        check(fault_stat && !dsg_fet_en && alert, "R7 sticky without oc", int'(fault_stat), 1);
        release_fault();

        // R5: after a dropout, a new onset starts a full delay
        measure(0, 50, -5, NO_EVT, 0, NO_EVT, trip, ok, exp);
        check(trip == -1, "R5 dropout no trip", trip, -1);
        measure(0, 51, 10000, NO_EVT, 0, NO_EVT, trip, ok, exp);
        check(trip == exp, "R5 restart full delay", trip, exp);
        release_fault();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule